// File: doc/BRIEF.md
# Channel-Grouped DMA Interrupt Event Unit

This unit gathers single-cycle event pulses coming from a set of DMA channels and turns them into one interrupt request for a processor. Each channel owns a group of four consecutive event bits, so event number e lands in bit e of a raw pending register, and channel c occupies bits 4c to 4c+3. Pending bits stay latched until software clears them, whether or not they are enabled.

Software reaches the unit through a small word-addressed register port with a write strobe and a combinational read path. It can enable or acknowledge a whole channel group with one write of the mask 0xF shifted left by four times the channel number, or touch a single event alone. The interrupt line is the OR of all enabled pending bits, taken through one register stage.

Top module: `dma_evirq_unit`

## Requirements
- R1: An event pulse on evPulse bit e sets raw pending bit e at the next clock edge; channel c's events are bits 4c..4c+3, and the raw register reads at word address 1.
- R2: Raw pending bits are latched and held even when the matching enable bit is 0.
- R3: Word address 2 reads the raw pending bits ANDed with the enable bits.
- R4: Word address 0 is the enable register: it reads back the last value written there, and writing 0xF shifted left by 4c enables exactly channel c's group.
- R5: Writing to word address 3 clears every raw bit whose data bit is 1; raw bits whose data bit is 0, including others in the same channel group, keep their value.
- R6: Word address 3 always reads as zero.
- R7: When an event pulse and a clear for the same bit fall in the same cycle, the bit is set afterwards.
- R8: irqOut equals the OR of (raw AND enable) as it stood one clock earlier.
- R9: After reset the raw and enable registers read zero and irqOut is low.
- R10: Writes to word addresses 1 and 2 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evPulse | input | 32 | One-cycle event pulses, bit e is event e |
| busAddr | input | 2 | Word address of the register access |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| irqOut | output | 1 | Registered combined interrupt request |

## Verification
The bench aims at a clear and an event hitting the same bit in one cycle, where a design giving clear the priority would lose the event and read the bit as zero. It clears one bit inside a channel group with neighbours pending, which catches a design that clears the whole group, and it raises events while their enables are off, which exposes a design that gates latching with the enable. It writes to the read-only addresses and watches the raw and enable values stay put, and it follows irqOut one cycle behind the masked value, so a combinational or two-stage interrupt path shows up as a mismatch.

// File: rtl/dma_evirq_pkg.sv
package dma_evirq_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_ENABLE = 2'd0,
    REG_RAW    = 2'd1,
    REG_MASKED = 2'd2,
    REG_CLEAR  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic wrEnable;
    logic wrClear;
    logic rdEnable;
    logic rdRaw;
    logic rdMasked;
  } ctlStrobes_t;

endpackage

// File: rtl/dma_evirq_ctrl.sv
module dma_evirq_ctrl
  import dma_evirq_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctlStrobes_t       strobes
);

  regSel_e sel;

  always_comb begin
    sel = regSel_e'(busAddr);
    strobes = '0;
    unique case (sel)
      REG_ENABLE: begin
        strobes.rdEnable = 1'b1;
        strobes.wrEnable = busWrEn;
      end
      REG_RAW:    strobes.rdRaw = 1'b1;
      REG_MASKED: strobes.rdMasked = 1'b1;
      REG_CLEAR:  strobes.wrClear = busWrEn;
      default:    strobes = '0;
    endcase
  end

endmodule

// File: rtl/dma_evirq_datapath.sv
module dma_evirq_datapath
  import dma_evirq_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int EV_PER_CH = 4,
  parameter int DATA_W    = 32,
  localparam int NUM_EV   = NUM_CH * EV_PER_CH
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [NUM_EV-1:0] evPulse,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [NUM_EV-1:0] rawQ,
  output logic [NUM_EV-1:0] enQ,
  output logic              irqOut
);

  logic [NUM_EV-1:0] clrMask;
  logic [NUM_EV-1:0] rawNext;
  logic [NUM_EV-1:0] maskedSts;
  logic [NUM_EV-1:0] rdSel;

  assign clrMask = strobes.wrClear ? busWrData[NUM_EV-1:0] : '0;

  // per-channel group update: an event in the same cycle outranks a clear
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gGroup
    localparam int LO = ch * EV_PER_CH;
    assign rawNext[LO +: EV_PER_CH] =
      (rawQ[LO +: EV_PER_CH] & ~clrMask[LO +: EV_PER_CH]) |
      evPulse[LO +: EV_PER_CH];
    assign maskedSts[LO +: EV_PER_CH] =
      rawQ[LO +: EV_PER_CH] & enQ[LO +: EV_PER_CH];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawQ   <= '0;
      enQ    <= '0;
      irqOut <= 1'b0;
    end else begin
      rawQ   <= rawNext;
      irqOut <= |maskedSts;
      if (strobes.wrEnable) enQ <= busWrData[NUM_EV-1:0];
    end
  end

  always_comb begin
    rdSel = '0;
    if (strobes.rdEnable) rdSel = enQ;
    if (strobes.rdRaw)    rdSel = rawQ;
    if (strobes.rdMasked) rdSel = maskedSts;
    busRdData = DATA_W'(rdSel);
  end

endmodule

// File: rtl/dma_evirq_unit.sv
module dma_evirq_unit
  import dma_evirq_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int EV_PER_CH = 4,
  parameter int DATA_W    = 32,
  localparam int NUM_EV   = NUM_CH * EV_PER_CH
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_EV-1:0] evPulse,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqOut
);

  ctlStrobes_t       strobes;
  logic [NUM_EV-1:0] rawQ;
  logic [NUM_EV-1:0] enQ;

  dma_evirq_ctrl uCtrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobes (strobes)
  );

  dma_evirq_datapath #(
    .NUM_CH    (NUM_CH),
    .EV_PER_CH (EV_PER_CH),
    .DATA_W    (DATA_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .evPulse   (evPulse),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .rawQ      (rawQ),
    .enQ       (enQ),
    .irqOut    (irqOut)
  );

endmodule

// File: rtl/dma_evirq_unit_chk.sv
module dma_evirq_unit_chk #(
  parameter int NUM_EV = 32,
  parameter int DATA_W = 32
)(
  input logic              clk,
  input logic              rstN,
  input logic [NUM_EV-1:0] evPulse,
  input logic [1:0]        busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic [NUM_EV-1:0] rawQ,
  input logic [NUM_EV-1:0] enQ,
  input logic              irqOut
);

  logic clrWr;
  assign clrWr = busWrEn && (busAddr == 2'd3);

  AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (|evPulse) |=> ((rawQ & $past(evPulse)) == $past(evPulse))); // R1

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && |(evPulse & busWrData[NUM_EV-1:0])) |=>
    ((rawQ & $past(evPulse & busWrData[NUM_EV-1:0])) ==
     $past(evPulse & busWrData[NUM_EV-1:0]))); // R7

  AST_CLEAR_LOCAL: assert property (@(posedge clk) disable iff (!rstN)
    clrWr |=> ((rawQ & ~$past(busWrData[NUM_EV-1:0])) ==
               ($past(rawQ | evPulse) & ~$past(busWrData[NUM_EV-1:0])))); // R5

  AST_RAW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!(|evPulse) && !clrWr) |=> $stable(rawQ)); // R10

  AST_IRQ_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == |($past(rawQ & enQ)))); // R8

  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd3) |-> (busRdData == '0)); // R6

endmodule

bind dma_evirq_unit dma_evirq_unit_chk #(
  .NUM_EV (NUM_EV),
  .DATA_W (DATA_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .evPulse   (evPulse),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .rawQ      (rawQ),
  .enQ       (enQ),
  .irqOut    (irqOut)
);

// File: tb/dma_evirq_unit_test.sv
`timescale 1ns/1ps
module dma_evirq_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] evPulse = '0;
  logic [1:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] mRaw = '0;
  logic [31:0] mEn = '0;
  logic        mIrq = 1'b0;

  always #2 clk = ~clk;

  dma_evirq_unit uut (
    .clk(clk), .rstN(rstN), .evPulse(evPulse), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqOut(irqOut)
  );

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mRaw = '0; mEn = '0; mIrq = 1'b0;
    end else begin
      mIrq = |(mRaw & mEn);
      mRaw = (mRaw & ~((busWrEn && busAddr == 2'd3) ? busWrData : 32'h0)) | evPulse;
      if (busWrEn && busAddr == 2'd0) mEn = busWrData;
    end
  end

  function automatic logic [31:0] modelRead(input logic [1:0] a);
    case (a)
      2'd0: return mEn;
      2'd1: return mRaw;
      2'd2: return mRaw & mEn;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the reference on every falling edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      case (busAddr)
        2'd0: check("R4 enable read", busRdData, modelRead(busAddr));
        2'd1: check("R1 raw read", busRdData, modelRead(busAddr));
        2'd2: check("R3 masked read", busRdData, modelRead(busAddr));
        default: check("R6 clear read", busRdData, modelRead(busAddr));
      endcase
      check("R8 irq", {31'h0, irqOut}, {31'h0, mIrq});
    end
  end

  task automatic step(input logic [31:0] ev, input logic [1:0] a,
                      input logic we, input logic [31:0] d);
    @(posedge clk); #1;
    evPulse = ev; busAddr = a; busWrEn = we; busWrData = d;
  endtask

  task automatic readAt(input logic [1:0] a, input logic [31:0] exp, input string tag);
    step(32'h0, a, 1'b0, 32'h0);
    @(negedge clk);
    check(tag, busRdData, exp);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R9 irq after reset", {31'h0, irqOut}, 32'h0);
    readAt(2'd0, 32'h0, "R9 enable after reset");
    readAt(2'd1, 32'h0, "R9 raw after reset");

    // event 5 (channel 1, bit 1) while disabled
    step(32'h20, 2'd1, 1'b0, 32'h0);
    readAt(2'd1, 32'h20, "R2 latched while disabled");
    check("R2 no irq while disabled", {31'h0, irqOut}, 32'h0);

    // enable channel 1 group
    step(32'h0, 2'd0, 1'b1, 32'hF << 4);
    readAt(2'd0, 32'h0000_00F0, "R4 channel group enable");
    readAt(2'd2, 32'h20, "R3 masked");
    check("R8 irq high", {31'h0, irqOut}, 32'h1);

    // writes to read-only addresses
    step(32'h0, 2'd1, 1'b1, 32'hFFFF_FFFF);
    step(32'h0, 2'd2, 1'b1, 32'hFFFF_FFFF);
    readAt(2'd1, 32'h20, "R10 raw unchanged");
    readAt(2'd0, 32'hF0, "R10 enable unchanged");

    // neighbours pending, clear one
    step(32'h50, 2'd1, 1'b0, 32'h0);
    step(32'h0, 2'd3, 1'b1, 32'h20);
    readAt(2'd1, 32'h50, "R5 single clear in group");
    readAt(2'd3, 32'h0, "R6 clear reads zero");

    // event and clear on the same bit
    step(32'h10, 2'd3, 1'b1, 32'h10);
    readAt(2'd1, 32'h50, "R7 event beats clear");

    // clear whole group, interrupt drops one cycle later
    step(32'h0, 2'd3, 1'b1, 32'hF << 4);
    readAt(2'd1, 32'h0, "R5 group clear");
    @(negedge clk);
    check("R8 irq low", {31'h0, irqOut}, 32'h0);

    // mixed traffic on all channels
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ev;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      ev = (lfsr[3:0] == 4'h0) ? (32'h1 << lfsr[8:4]) : 32'h0;
      if (lfsr[9]) ev = ev | (32'h1 << lfsr[14:10]);
      step(ev, lfsr[16:15], lfsr[17] & lfsr[18],
           lfsr[19] ? (32'hF << (4 * lfsr[22:20])) : (32'h1 << lfsr[27:23]));
    end
    step(32'h0, 2'd2, 1'b0, 32'h0);
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule